// File: doc/BRIEF.md
# Cascaded-Timer Fractional Baud Clock

This block derives a serial-port base clock whose average rate is a fraction of an integer division of the system clock. Two 8-bit compare-match timers are chained. The first timer steps on a prescaled enable and produces a square wave. The second timer steps once for each wrap of the first timer and produces an enable window. The base clock is the AND of the two timer waves, so a fixed share of the first timer's pulses is removed. For example, a 32 MHz system clock with a /2 prescale, a first timer wrapping at 3 and rising at 1, and a second timer wrapping at 3 and rising at 0 gives a 4 MHz wave gated to 3 MHz on average. A bit tick is emitted on every sixteenth rising edge of the base clock, which gives 187.5 kbps.

Everything runs on one clock. The prescaler, the timer steps and the edge detection are single-cycle enables. The compare values and the prescale select come from outside. The shift register that uses the ticks is not part of this block.

Top module: `cascade_baud_gen`

## Requirements
- R1: While `rst` is high, and on the first sample after it is released, `base_clk`, `base_rise` and `bit_tick` are 0. Both timer counters and both timer waves start at zero.
- R2: `psel` value p (0..3) makes the first timer step once every 2^p clock cycles. The first step after reset comes on the (2^p)-th clock edge.
- R3: The first timer compares its count with `t0_a` and with `t0_b` on each step. On a match with `t0_a` the count returns to 0 and the wave goes to 0. Otherwise the count increments, and a match with `t0_b` sets the wave to 1. When both values are equal, the `t0_a` match wins and the wave stays 0. As a result, the base clock has no pulses when `t0_b` >= `t0_a`.
- R4: The second timer steps once for each `t0_a` match of the first timer. It follows the same rules with `t1_a` and `t1_b`, including the priority of the A match. When `t1_b` >= `t1_a`, its wave never rises.
- R5: `base_clk` is the AND of the two timer waves. Over (t1_a+1) first-timer periods, exactly t1_a−t1_b base pulses pass. Each pulse is high for (t0_a−t0_b)·2^p cycles.
- R6: `base_rise` is high for exactly the one cycle in which `base_clk` first reads 1 after reading 0. It is never high in two consecutive cycles.
- R7: `bit_tick` is high together with every sixteenth `base_rise` counted from reset, and at no other time.
- R8: A compare value of 0 matches on the step taken directly after the counter clears.
- R9: With p=1, `t0_a`=3, `t0_b`=1, `t1_a`=3 and `t1_b`=0, exactly 12 base pulses pass during the first 16 first-timer periods after reset. The first period is blocked because the second timer's wave starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 2 | Prescale select, divide by 2^psel |
| t0_a | input | 8 | First timer wrap / clear compare |
| t0_b | input | 8 | First timer set compare |
| t1_a | input | 8 | Second timer wrap / clear compare |
| t1_b | input | 8 | Second timer set compare |
| base_clk | output | 1 | Gated base clock level |
| base_rise | output | 1 | One-cycle strobe on each base clock rising edge |
| bit_tick | output | 1 | One-cycle strobe every 16 base clock rises |

## Verification
In the same clock cycle, a timer's clear compare and its set compare can both match, and the first timer's wrap can also step and update the second timer. Setting equal A and B values forces the two matches together. The bench then expects zero base pulses, because the clear must win. With unequal values, the second timer's wave changes on the same edge on which the first timer's wave falls. Pulse widths and pulse counts that exactly follow the arithmetic prove that no shortened or extra pulse leaks through at that edge. The sweep covers every combination of compare values from 0 to 3 and every prescale setting.

// File: rtl/cascade_baud_gen.sv
module cascade_baud_gen #(
  parameter int CW      = 8,
  parameter int BIT_DIV = 16,
  parameter int PSW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PSW-1:0] psel,
  input  logic [CW-1:0] t0_a,
  input  logic [CW-1:0] t0_b,
  input  logic [CW-1:0] t1_a,
  input  logic [CW-1:0] t1_b,
  output logic          base_clk,
  output logic          base_rise,
  output logic          bit_tick
);
  localparam int PDW = (1 << PSW) - 1;
  localparam int TW  = $clog2(BIT_DIV);

  logic [PDW-1:0] pre_cnt;
  logic [PDW-1:0] pre_mask;
  logic           pre_en;
  logic [CW-1:0]  c0, c1;
  logic           o0, o1;
  logic           m0a, m0b, m1a, m1b;
  logic           base_q;
  logic [TW-1:0]  tick_cnt;

  assign pre_mask = PDW'((1 << psel) - 1);
  assign pre_en   = (pre_cnt & pre_mask) == pre_mask;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  assign m0a = pre_en && (c0 == t0_a);
  assign m0b = pre_en && (c0 == t0_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      c0 <= '0;
      o0 <= 1'b0;
    end else if (pre_en) begin
      c0 <= m0a ? '0 : c0 + 1'b1;
      if (m0a)      o0 <= 1'b0;
      else if (m0b) o0 <= 1'b1;
    end
  end

  assign m1a = m0a && (c1 == t1_a);
  assign m1b = m0a && (c1 == t1_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      c1 <= '0;
      o1 <= 1'b0;
    end else if (m0a) begin
      c1 <= m1a ? '0 : c1 + 1'b1;
      if (m1a)      o1 <= 1'b0;
      else if (m1b) o1 <= 1'b1;
    end
  end

  assign base_clk  = o0 & o1;
  assign base_rise = base_clk & ~base_q;
  assign bit_tick  = base_rise && (tick_cnt == TW'(BIT_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= 1'b0;
      tick_cnt <= '0;
    end else begin
      base_q <= base_clk;
      if (base_rise)
        tick_cnt <= bit_tick ? '0 : tick_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cascade_baud_gen_sva.sv
module cascade_baud_gen_sva #(
  parameter int CW      = 8,
  parameter int BIT_DIV = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          pre_en,
  input logic [CW-1:0] c0,
  input logic [CW-1:0] t0_a,
  input logic          o0,
  input logic          base_clk,
  input logic          base_rise,
  input logic          bit_tick
);
  int unsigned seen;

  always_ff @(posedge clk) begin
    if (rst)            seen <= 0;
    else if (base_rise) seen <= (seen == BIT_DIV - 1) ? 0 : seen + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!base_clk && !base_rise && !bit_tick));

  p_t0_fall_on_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(o0) |-> $past(pre_en && (c0 == t0_a)));

  p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
    base_rise |=> !base_rise);

  p_rise_level_r6: assert property (@(posedge clk) disable iff (rst)
    base_rise |-> base_clk);

  p_tick_on_sixteenth_r7: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> (base_rise && seen == BIT_DIV - 1));

  p_tick_not_missed_r7: assert property (@(posedge clk) disable iff (rst)
    (base_rise && seen == BIT_DIV - 1) |-> bit_tick);
endmodule

bind cascade_baud_gen cascade_baud_gen_sva #(.CW(CW), .BIT_DIV(BIT_DIV)) u_sva (
  .clk(clk), .rst(rst), .pre_en(pre_en), .c0(c0), .t0_a(t0_a), .o0(o0),
  .base_clk(base_clk), .base_rise(base_rise), .bit_tick(bit_tick)
);

// File: tb/cascade_baud_gen_bench.sv
module cascade_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] psel = '0;
  logic [7:0] t0_a = '0, t0_b = '0, t1_a = '0, t1_b = '0;
  logic       base_clk, base_rise, bit_tick;
  int         errors = 0;
  int         checks = 0;
  int         cycles = 0;

  cascade_baud_gen u_cascade_baud_gen (
    .clk(clk), .rst(rst), .psel(psel), .t0_a(t0_a), .t0_b(t0_b),
    .t1_a(t1_a), .t1_b(t1_b), .base_clk(base_clk),
    .base_rise(base_rise), .bit_tick(bit_tick)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL WDOG: run hung, actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rises(int a0, int b0, int a1, int b1, int n);
    int cnt = 0;
    if (b0 >= a0 || b1 >= a1) return 0;
    for (int j = 1; j < n; j++) begin
      int v = (j - 1) % (a1 + 1);
      if (v >= b1 && v < a1) cnt++;
    end
    return cnt;
  endfunction

  task automatic run_cfg(input int ps, input int a0, input int b0,
                         input int a1, input int b1, input int k,
                         input string tag);
    int div = 1 << ps;
    int n   = (a1 + 1) * k;
    int len = n * (a0 + 1) * div;
    int rises = 0, ticks = 0, hw = 0, wbad = 0, dbl = 0;
    bit prev_rise = 0;
    int er;
    psel = 2'(ps);
    t0_a = 8'(a0); t0_b = 8'(b0); t1_a = 8'(a1); t1_b = 8'(b1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {29'd0, base_clk, base_rise, bit_tick}, 0);
    rst = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (base_rise) rises++;
      if (bit_tick) ticks++;
      if (bit_tick && !base_rise) dbl++;
      if (base_rise && prev_rise) dbl++;
      prev_rise = base_rise;
      if (base_clk) hw++;
      else if (hw > 0) begin
        if (hw != (a0 - b0) * div) wbad++;
        hw = 0;
      end
    end
    er = exp_rises(a0, b0, a1, b1, n);
    check(tag, rises, er);
    check("R7 tick count", ticks, er / 16);
    check("R6 strobe shape", dbl, 0);
    if (er > 0) check("R5 pulse width", wbad, 0);
  endtask

  initial begin
    // R9: 3/4 gating over four second-timer periods
    run_cfg(1, 3, 1, 3, 0, 4, "R9 pass 12 of 16");
    // R2: every prescale setting
    for (int p = 0; p < 4; p++) run_cfg(p, 3, 1, 3, 0, 8, "R2 prescale");
    // R3, R4, R5, R8: all compare values 0..3 at no prescale
    for (int a0 = 0; a0 < 4; a0++)
      for (int b0 = 0; b0 < 4; b0++)
        for (int a1 = 0; a1 < 4; a1++)
          for (int b1 = 0; b1 < 4; b1++) begin
            string tg;
            if (b0 >= a0)              tg = "R3 A-priority t0";
            else if (b1 >= a1)         tg = "R4 A-priority t1";
            else if (b0 == 0 || b1 == 0) tg = "R8 zero compare";
            else                       tg = "R5 gated count";
            run_cfg(0, a0, b0, a1, b1, 8, tg);
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule